// File: doc/BRIEF.md
# ISA Slave Select and Byte-Lane Steering

This block sits between an 8-bit or 16-bit ISA I/O bus and an internal register file. It compares the upper five bits of the 10-bit I/O address against five strap inputs. A strap left open reads as 1, and a strap tied low reads as 0. When the upper bits match and address enable is asserted, the chip is selected. The lower five address bits alone pick the internal register. The width-sense input, the high-byte enable and address bit 0 only decide which data byte lane carries the transfer.

On the internal side the block has a register offset, a byte-enable pair, one-cycle read and write strobes, a write-data bus, and a read-data bus with an acknowledge. A remote read pulls the open-collector ready line low until the register file acknowledges or a bounded wait expires. Two read-only status locations are answered locally and are never forwarded: one reports the access width and one reports interrupt status. The bus strobes are taken as synchronous to the block clock.

Top module: `isa_slave_glue`

## Requirements
- R1: An access starts only when `aen_ni` is low and `addr_i[9:5]` equals `strap_i`. Otherwise no strobe is issued, neither data lane is driven and `iocs16_no` stays high.
- R2: Each strap bit is compared as its own value. With `strap_i`=5'b10110 the base is 0x2C0, and with `strap_i`=5'b11111 the base is 0x3E0.
- R3: With `bus8_i`=1 and `bhe_ni`=1, every offset uses the low lane (`reg_be_o`=2'b01, bit 0 = low byte). `iocs16_no` stays high.
- R4: With `bus8_i`=0 and `bhe_ni`=0, offset 0x18 uses both lanes (`reg_be_o`=2'b11). The upper byte is the first data queue and the lower byte is the second.
- R5: With `bus8_i`=0 and `bhe_ni`=0, an odd offset uses only the upper lane (`reg_be_o`=2'b10).
- R6: With `bus8_i`=0 and `bhe_ni`=1, an even offset uses only the low lane. On a read the upper lane is not driven, and on a write the upper byte is masked (`reg_be_o`=2'b01).
- R7: Any other combination (16-bit with `bhe_ni`=0 at an even offset other than 0x18, 16-bit with `bhe_ni`=1 at an odd offset, or 8-bit with `bhe_ni`=0) gives no strobe, no lane driven and no wait.
- R8: `iocs16_no` is low exactly while the chip is selected and the decoded lane includes the upper byte.
- R9: A write produces one `reg_wr_o` pulse in the cycle after `iow_ni` is first seen high. It carries the offset, the lane mask and the bus data sampled in the last cycle `iow_ni` was low.
- R10: A remote read gives a one-cycle `reg_rd_o`. `iochrdy_pull_o` is high from the cycle after the read strobe falls until the acknowledge. The acknowledged data is then driven on the decoded lanes while `ior_ni` stays low, and undriven lanes read as 0.
- R11: Without an acknowledge, `iochrdy_pull_o` is released after `WAIT_MAX` cycles and the read returns 0.
- R12: Offset 0x05 returns {6'b0, high byte enabled, 16-bit bus}, and offset 0x07 returns `irq_stat_i`. Both are placed on the decoded lane with no internal strobe and no wait. Writes to either offset issue no strobe.
- R13: After reset no lane is driven, `iochrdy_pull_o` is low, `iocs16_no` is high and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 10 | ISA I/O address |
| aen_ni | input | 1 | Address enable, active low |
| strap_i | input | 5 | Base-address straps (open reads 1) |
| bus8_i | input | 1 | Width sense: 1 = 8-bit bus, 0 = 16-bit bus |
| bhe_ni | input | 1 | High-byte enable, active low |
| ior_ni | input | 1 | I/O read strobe, active low |
| iow_ni | input | 1 | I/O write strobe, active low |
| data_i | input | 16 | Bus data seen by the block |
| data_o | output | 16 | Read data for the bus |
| data_lo_oe_o | output | 1 | Drive enable for the low lane |
| data_hi_oe_o | output | 1 | Drive enable for the upper lane |
| iocs16_no | output | 1 | 16-bit cycle indication, active low |
| iochrdy_pull_o | output | 1 | 1 pulls the open-collector ready line low |
| irq_stat_i | input | 8 | Interrupt status byte for offset 0x07 |
| reg_addr_o | output | 5 | Internal register offset |
| reg_be_o | output | 2 | Internal byte enables {upper, low} |
| reg_wdata_o | output | 16 | Internal write data |
| reg_wr_o | output | 1 | Internal write strobe, one cycle |
| reg_rd_o | output | 1 | Internal read strobe, one cycle |
| reg_rdata_i | input | 16 | Internal read data, lane aligned |
| reg_ack_i | input | 1 | Internal read acknowledge |

## Verification
The assertions take three things for granted about the inputs:
- The bus strobes are already in the block clock domain and never fall together.
- Address, width sense and high-byte enable stay steady while a strobe is low.
- `reg_ack_i` is raised only while a remote read is waiting.

The stimulus keeps to these rules by driving every input on the falling clock edge. It changes the address only between cycles, and it raises the acknowledge only after it has seen the wait line asserted. Each case then holds the strobe for a fixed number of cycles before releasing it.

// File: rtl/isa_glue_pkg.sv
package isa_glue_pkg;
  localparam int OFF_W = 5;
  typedef logic [OFF_W-1:0] off_t;
  typedef logic [1:0] lane_t;  // {upper, low}

  localparam lane_t LANE_NONE = 2'b00;
  localparam lane_t LANE_LO   = 2'b01;
  localparam lane_t LANE_HI   = 2'b10;
  localparam lane_t LANE_BOTH = 2'b11;

  typedef enum logic [1:0] {
    CYC_IDLE,
    CYC_RD_WAIT,
    CYC_RD_HOLD,
    CYC_WR_HOLD
  } cyc_state_e;

  function automatic lane_t lane_pick(input logic bus8, input logic bhe_n,
                                      input off_t off, input off_t dual_off);
    lane_t l;
    if (bus8)             l = bhe_n ? LANE_LO : LANE_NONE;
    else if (!bhe_n)      l = (off == dual_off) ? LANE_BOTH :
                              (off[0] ? LANE_HI : LANE_NONE);
    else                  l = off[0] ? LANE_NONE : LANE_LO;
    return l;
  endfunction
endpackage

// File: rtl/isa_addr_match.sv
module isa_addr_match #(
  parameter int ADDR_W = 10,
  parameter int OFF_W  = 5,
  localparam int SEL_W = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              aen_ni,
  input  logic [SEL_W-1:0]  strap_i,
  output logic              sel_o,
  output logic [OFF_W-1:0]  off_o
);
  logic [SEL_W-1:0] diff;

  generate
    for (genvar i = 0; i < SEL_W; i++) begin : g_cmp
      assign diff[i] = addr_i[OFF_W+i] ^ strap_i[i];
    end
  endgenerate

  assign sel_o = !aen_ni && (diff == '0);
  assign off_o = addr_i[OFF_W-1:0];
endmodule

// File: rtl/isa_lane_steer.sv
module isa_lane_steer
  import isa_glue_pkg::*;
#(
  parameter off_t DUAL_OFF = 5'h18
) (
  input  logic  sel_i,
  input  logic  bus8_i,
  input  logic  bhe_ni,
  input  off_t  off_i,
  output lane_t lane_o,
  output logic  iocs16_no
);
  assign lane_o    = sel_i ? lane_pick(bus8_i, bhe_ni, off_i, DUAL_OFF) : LANE_NONE;
  assign iocs16_no = !lane_o[1];
endmodule

// File: rtl/isa_cycle_ctrl.sv
module isa_cycle_ctrl
  import isa_glue_pkg::*;
#(
  parameter int   DATA_W    = 16,
  parameter int   IRQ_W     = 8,
  parameter int   WAIT_MAX  = 8,
  parameter off_t WSTAT_OFF = 5'h05,
  parameter off_t ISTAT_OFF = 5'h07,
  localparam int  BYTE_W    = DATA_W / 2,
  localparam int  TMR_W     = $clog2(WAIT_MAX + 1) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ior_ni,
  input  logic              iow_ni,
  input  lane_t             lane_i,
  input  off_t              off_i,
  input  logic              bus8_i,
  input  logic              bhe_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic [IRQ_W-1:0]  irq_stat_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_lo_oe_o,
  output logic              data_hi_oe_o,
  output logic              iochrdy_pull_o,
  output off_t              reg_addr_o,
  output lane_t             reg_be_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_wr_o,
  output logic              reg_rd_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  input  logic              reg_ack_i
);
  cyc_state_e        state_q;
  logic              ior_q, iow_q;
  lane_t             lane_q;
  off_t              off_q;
  logic [DATA_W-1:0] rdata_q, wdata_q;
  logic [TMR_W-1:0]  tmr_q;

  logic rd_start, wr_start, is_local, hit_local;
  logic [BYTE_W-1:0] local_val;
  logic [DATA_W-1:0] local_word;

  assign rd_start  = ior_q && !ior_ni && (lane_i != LANE_NONE);
  assign wr_start  = iow_q && !iow_ni && (lane_i != LANE_NONE);
  assign hit_local = (off_i == WSTAT_OFF) || (off_i == ISTAT_OFF);
  assign is_local  = (off_q == WSTAT_OFF) || (off_q == ISTAT_OFF);

  always_comb begin
    local_val = '0;
    if (off_i == WSTAT_OFF) local_val[1:0] = {!bhe_ni, !bus8_i};
    else                    local_val      = BYTE_W'(irq_stat_i);
    local_word = (lane_i == LANE_HI) ? {local_val, {BYTE_W{1'b0}}}
                                     : {{BYTE_W{1'b0}}, local_val};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= CYC_IDLE;
      ior_q    <= 1'b1;
      iow_q    <= 1'b1;
      lane_q   <= LANE_NONE;
      off_q    <= '0;
      rdata_q  <= '0;
      wdata_q  <= '0;
      tmr_q    <= '0;
      reg_wr_o <= 1'b0;
      reg_rd_o <= 1'b0;
    end else begin
      ior_q    <= ior_ni;
      iow_q    <= iow_ni;
      reg_wr_o <= 1'b0;
      reg_rd_o <= 1'b0;
      unique case (state_q)
        CYC_IDLE: begin
          tmr_q <= '0;
          if (rd_start) begin
            lane_q <= lane_i;
            off_q  <= off_i;
            if (hit_local) begin
              rdata_q <= local_word;
              state_q <= CYC_RD_HOLD;
            end else begin
              reg_rd_o <= 1'b1;
              state_q  <= CYC_RD_WAIT;
            end
          end else if (wr_start) begin
            lane_q  <= lane_i;
            off_q   <= off_i;
            wdata_q <= data_i;
            state_q <= CYC_WR_HOLD;
          end
        end
        CYC_RD_WAIT: begin
          tmr_q <= tmr_q + 1'b1;
          if (ior_ni) begin
            state_q <= CYC_IDLE;
          end else if (reg_ack_i) begin
            rdata_q <= reg_rdata_i;
            state_q <= CYC_RD_HOLD;
          end else if (tmr_q == TMR_W'(WAIT_MAX - 1)) begin
            rdata_q <= '0;
            state_q <= CYC_RD_HOLD;
          end
        end
        CYC_RD_HOLD: begin
          if (ior_ni) state_q <= CYC_IDLE;
        end
        CYC_WR_HOLD: begin
          if (iow_ni) begin
            reg_wr_o <= !is_local;
            state_q  <= CYC_IDLE;
          end else begin
            wdata_q <= data_i;
          end
        end
        default: state_q <= CYC_IDLE;
      endcase
    end
  end

  logic rd_drive;
  assign rd_drive       = (state_q == CYC_RD_HOLD) && !ior_ni;
  assign data_lo_oe_o   = rd_drive && lane_q[0];
  assign data_hi_oe_o   = rd_drive && lane_q[1];
  assign data_o         = {data_hi_oe_o ? rdata_q[DATA_W-1:BYTE_W] : {BYTE_W{1'b0}},
                           data_lo_oe_o ? rdata_q[BYTE_W-1:0]      : {BYTE_W{1'b0}}};
  assign iochrdy_pull_o = (state_q == CYC_RD_WAIT);
  assign reg_addr_o     = off_q;
  assign reg_be_o       = lane_q;
  assign reg_wdata_o    = wdata_q;

  logic [TMR_W-1:0] pull_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             pull_cnt_q <= '0;
    else if (iochrdy_pull_o) pull_cnt_q <= pull_cnt_q + 1'b1;
    else                     pull_cnt_q <= '0;
  end

  // R10
  rd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_o |=> !reg_rd_o);
  // R9
  wr_after_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_wr_o) |-> $past(iow_ni));
  // R11
  wait_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_cnt_q <= TMR_W'(WAIT_MAX));
  // R10
  drive_after_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_lo_oe_o || data_hi_oe_o) |-> !iochrdy_pull_o);
  // R12
  local_no_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_o || reg_wr_o) |-> (reg_addr_o != WSTAT_OFF && reg_addr_o != ISTAT_OFF));
  // R7
  no_empty_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_o || reg_wr_o) |-> (reg_be_o != LANE_NONE));
endmodule

// File: rtl/isa_slave_glue.sv
module isa_slave_glue
  import isa_glue_pkg::*;
#(
  parameter int   ADDR_W    = 10,
  parameter int   DATA_W    = 16,
  parameter int   IRQ_W     = 8,
  parameter int   WAIT_MAX  = 8,
  parameter off_t DUAL_OFF  = 5'h18,
  parameter off_t WSTAT_OFF = 5'h05,
  parameter off_t ISTAT_OFF = 5'h07,
  localparam int  SEL_W     = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              aen_ni,
  input  logic [SEL_W-1:0]  strap_i,
  input  logic              bus8_i,
  input  logic              bhe_ni,
  input  logic              ior_ni,
  input  logic              iow_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_lo_oe_o,
  output logic              data_hi_oe_o,
  output logic              iocs16_no,
  output logic              iochrdy_pull_o,
  input  logic [IRQ_W-1:0]  irq_stat_i,
  output logic [OFF_W-1:0]  reg_addr_o,
  output logic [1:0]        reg_be_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_wr_o,
  output logic              reg_rd_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  input  logic              reg_ack_i
);
  logic  sel;
  off_t  off;
  lane_t lane;

  isa_addr_match #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_match (
    .addr_i (addr_i),
    .aen_ni (aen_ni),
    .strap_i(strap_i),
    .sel_o  (sel),
    .off_o  (off)
  );

  isa_lane_steer #(.DUAL_OFF(DUAL_OFF)) i_steer (
    .sel_i    (sel),
    .bus8_i   (bus8_i),
    .bhe_ni   (bhe_ni),
    .off_i    (off),
    .lane_o   (lane),
    .iocs16_no(iocs16_no)
  );

  isa_cycle_ctrl #(
    .DATA_W(DATA_W), .IRQ_W(IRQ_W), .WAIT_MAX(WAIT_MAX),
    .WSTAT_OFF(WSTAT_OFF), .ISTAT_OFF(ISTAT_OFF)
  ) i_cycle (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ior_ni        (ior_ni),
    .iow_ni        (iow_ni),
    .lane_i        (lane),
    .off_i         (off),
    .bus8_i        (bus8_i),
    .bhe_ni        (bhe_ni),
    .data_i        (data_i),
    .irq_stat_i    (irq_stat_i),
    .data_o        (data_o),
    .data_lo_oe_o  (data_lo_oe_o),
    .data_hi_oe_o  (data_hi_oe_o),
    .iochrdy_pull_o(iochrdy_pull_o),
    .reg_addr_o    (reg_addr_o),
    .reg_be_o      (reg_be_o),
    .reg_wdata_o   (reg_wdata_o),
    .reg_wr_o      (reg_wr_o),
    .reg_rd_o      (reg_rd_o),
    .reg_rdata_i   (reg_rdata_i),
    .reg_ack_i     (reg_ack_i)
  );

  // R1
  unsel_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel |-> iocs16_no);
  // R8
  upper_cs16_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && !bus8_i && !bhe_ni && off[0]) |-> !iocs16_no);
endmodule

// File: tb/test_isa_slave_glue.sv
module test_isa_slave_glue;
  localparam int PERIOD   = 10;
  localparam int WAIT_MAX = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0]  addr = '0;
  logic        aen_n = 1'b0;
  logic [4:0]  strap = 5'b10110;
  logic        bus8 = 1'b0, bhe_n = 1'b1, ior_n = 1'b1, iow_n = 1'b1;
  logic [15:0] din = '0, rdata = '0;
  logic [7:0]  irq = 8'hA5;
  logic        ack = 1'b0;
  logic [15:0] dout, wdata;
  logic        lo_oe, hi_oe, cs16_n, pull, wr, rd;
  logic [4:0]  raddr;
  logic [1:0]  be;
  logic [9:0]  base = 10'h2C0;

  always #(PERIOD/2) clk = ~clk;

  isa_slave_glue #(.WAIT_MAX(WAIT_MAX)) i_isa_slave_glue (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .aen_ni(aen_n), .strap_i(strap),
    .bus8_i(bus8), .bhe_ni(bhe_n), .ior_ni(ior_n), .iow_ni(iow_n), .data_i(din),
    .data_o(dout), .data_lo_oe_o(lo_oe), .data_hi_oe_o(hi_oe), .iocs16_no(cs16_n),
    .iochrdy_pull_o(pull), .irq_stat_i(irq), .reg_addr_o(raddr), .reg_be_o(be),
    .reg_wdata_o(wdata), .reg_wr_o(wr), .reg_rd_o(rd), .reg_rdata_i(rdata),
    .reg_ack_i(ack)
  );

  int total = 0, bad = 0;
  bit done = 0;

  typedef struct {
    bit wr; logic [4:0] a; logic [1:0] be; logic [15:0] d; string rq;
  } item_t;
  item_t q[$];

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
    end
  endtask

  // monitor: every internal strobe must match the next expected item
  always @(negedge clk) begin
    if (rst_n && (wr || rd)) begin
      if (q.size() == 0) begin
        check(0, "R7", "unexpected strobe", {raddr, be, wr, rd}, 0);
      end else begin
        item_t it;
        it = q.pop_front();
        check(it.wr == wr && it.wr != rd, it.rq, "strobe kind", {wr, rd}, {it.wr, !it.wr});
        check(it.a == raddr, it.rq, "reg addr", raddr, it.a);
        check(it.be == be, it.rq, "byte enable", be, it.be);
        if (it.wr) check(it.d == wdata, it.rq, "write data", wdata, it.d);
      end
    end
  end

  task automatic do_read(input logic [4:0] off, input bit b8, input bit bhen,
                         input bit remote, input int dly, input logic [15:0] ackd,
                         input logic [1:0] xlane, input logic [15:0] xdata,
                         input bit xcs, input string rq);
    @(negedge clk);
    addr = {base[9:5], off}; bus8 = b8; bhe_n = bhen; ior_n = 1'b0;
    if (xlane != 2'b00 && remote) q.push_back('{0, off, xlane, 16'h0, rq});
    @(negedge clk);
    check(cs16_n == xcs, rq, "iocs16", cs16_n, xcs);
    if (xlane != 2'b00 && remote) begin
      check(pull == 1'b1, rq, "wait asserted", pull, 1);
      if (dly >= 0) begin
        repeat (dly) @(negedge clk);
        ack = 1'b1; rdata = ackd;
        @(negedge clk);
        ack = 1'b0; rdata = '0;
      end else begin
        repeat (WAIT_MAX) @(negedge clk);
      end
    end else begin
      @(negedge clk);
    end
    check(pull == 1'b0, rq, "wait released", pull, 0);
    check({hi_oe, lo_oe} == xlane, rq, "lane enables", {hi_oe, lo_oe}, xlane);
    check(dout == xdata, rq, "read data", dout, xdata);
    ior_n = 1'b1;
    @(negedge clk);
    check({hi_oe, lo_oe} == 2'b00, rq, "lanes off after cycle", {hi_oe, lo_oe}, 0);
    check(q.size() == 0, rq, "missing strobe", q.size(), 0);
  endtask

  task automatic do_write(input logic [4:0] off, input bit b8, input bit bhen,
                          input logic [15:0] d1, input logic [15:0] d2,
                          input logic [1:0] xbe, input bit xstrobe, input string rq);
    @(negedge clk);
    addr = {base[9:5], off}; bus8 = b8; bhe_n = bhen; iow_n = 1'b0; din = d1;
    if (xstrobe) q.push_back('{1, off, xbe, d2, rq});
    @(negedge clk);
    din = d2;
    @(negedge clk);
    iow_n = 1'b1; din = 16'hDEAD;
    repeat (3) @(negedge clk);
    check(pull == 1'b0, rq, "no wait on write", pull, 0);
    check(q.size() == 0, rq, "missing write strobe", q.size(), 0);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      check(0, "ALL", "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    check({hi_oe, lo_oe} == 2'b00, "R13", "lanes at reset", {hi_oe, lo_oe}, 0);
    check(pull == 1'b0, "R13", "wait at reset", pull, 0);
    check(wr == 1'b0 && rd == 1'b0, "R13", "strobes at reset", {wr, rd}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cs16_n == 1'b1, "R13", "iocs16 idle", cs16_n, 1);

    // R3 8-bit bus, low lane
    do_write(5'h02, 1, 1, 16'h1111, 16'h0042, 2'b01, 1, "R3");
    do_read (5'h03, 1, 1, 1, 2, 16'h1234, 2'b01, 16'h0034, 1, "R3");
    // R9 latch at rising edge
    do_write(5'h0C, 1, 1, 16'h00AA, 16'h0055, 2'b01, 1, "R9");
    // R4 dual-lane FIFO offset
    do_read (5'h18, 0, 0, 1, 0, 16'hBEEF, 2'b11, 16'hBEEF, 0, "R4");
    do_write(5'h18, 0, 0, 16'h0000, 16'hCAFE, 2'b11, 1, "R4");
    // R5 odd offset, upper lane
    do_read (5'h09, 0, 0, 1, 1, 16'hA55A, 2'b10, 16'hA500, 0, "R5");
    do_write(5'h0B, 0, 0, 16'h1200, 16'h3400, 2'b10, 1, "R5");
    // R6 even offset, low lane only
    do_read (5'h10, 0, 1, 1, 3, 16'h7788, 2'b01, 16'h0088, 1, "R6");
    do_write(5'h14, 0, 1, 16'h0101, 16'h9A3C, 2'b01, 1, "R6");
    // R7 undefined combinations
    do_read (5'h10, 0, 0, 1, 0, 16'h0, 2'b00, 16'h0, 1, "R7");
    do_write(5'h09, 0, 1, 16'h1, 16'h2, 2'b00, 0, "R7");
    do_read (5'h02, 1, 0, 1, 0, 16'h0, 2'b00, 16'h0, 1, "R7");
    // R1 base mismatch and address enable
    base = 10'h3C0;
    do_read (5'h09, 0, 0, 1, 0, 16'h0, 2'b00, 16'h0, 1, "R1");
    base = 10'h2C0; aen_n = 1'b1;
    do_read (5'h09, 0, 0, 1, 0, 16'h0, 2'b00, 16'h0, 1, "R1");
    do_write(5'h02, 1, 1, 16'h1, 16'h2, 2'b00, 0, "R1");
    aen_n = 1'b0;
    // R2 all straps open
    strap = 5'b11111; base = 10'h3E0;
    do_read (5'h04, 0, 1, 1, 1, 16'h0042, 2'b01, 16'h0042, 1, "R2");
    base = 10'h2C0;
    do_read (5'h04, 0, 1, 1, 1, 16'h0, 2'b00, 16'h0, 1, "R2");
    strap = 5'b10110;
    // R8 upper-lane access drives iocs16 low (checked inside), plus 8-bit odd
    do_read (5'h0D, 1, 1, 1, 0, 16'h00C3, 2'b01, 16'h00C3, 1, "R8");
    // R11 timeout
    do_read (5'h0A + 5'h01, 0, 0, 1, -1, 16'h0, 2'b10, 16'h0000, 0, "R11");
    // R12 local status registers
    do_read (5'h05, 0, 0, 0, 0, 16'h0, 2'b10, 16'h0300, 0, "R12");
    do_read (5'h07, 1, 1, 0, 0, 16'h0, 2'b01, 16'h00A5, 1, "R12");
    do_write(5'h07, 1, 1, 16'h1, 16'h2, 2'b01, 0, "R12");
    do_write(5'h05, 0, 0, 16'h1, 16'h2, 2'b10, 0, "R12");

    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule